// File: doc/BRIEF.md
# Ping-Pong Packet Receive Buffer

This block holds received packets for a single OUT-direction endpoint of a serial bus function. It has two storage banks, and the banks take turns. The link side pushes a packet one byte at a time into whichever bank is free. It then closes the packet with either a good-end strobe or an error strobe. Only a packet that ends well is handed over to the reader. A packet that ends with an error, or that grows past the bank capacity, is thrown away. In that case its bank stays free for the next attempt.

The reader side can be a processor or a DMA engine. It sees the oldest completed packet, and a size output gives that packet's byte count. The data port presents one byte at a time, and each read strobe steps to the next byte. When the reader is finished, it pulses a release trigger, which hands the bank back to the link side.

A pending flag tells software that at least one completed packet is waiting. A DMA request stays high while the head packet still has unread bytes. When both banks hold unread packets, a refuse output tells the link side to turn packets away. A synchronous flush input empties both banks at once.

Top module: `pp_rx_buffer`

## Requirements
- R1: After reset, `pkt_pending`, `dma_req` and `rx_refuse` are 0 and `rd_size` reads 0.
- R2: A good-end strobe on a packet of N bytes (0 ≤ N ≤ BANK_BYTES) sets `pkt_pending` on the next cycle. When no older packet is waiting, `rd_size` reads N from that cycle on. `rd_size` does not change while a packet is pending, unless there is a release or a flush.
- R3: `rd_data` shows the head packet's bytes in the order they arrived. It starts at byte 0, and each cycle with `rd_strobe` high advances it by one byte.
- R4: `dma_req` is 1 while a pending head packet has unread bytes. It drops in the cycle after the strobe that reads the last byte, and it is 0 for a zero-length packet.
- R5: `rd_strobe` has no effect in two cases: once the head packet is exhausted, and when nothing is pending. In both cases `rd_size` and `dma_req` keep their values, and the next packet is still read from its byte 0.
- R6: A `rd_release` pulse while a packet is pending frees that bank. The next pending packet, if there is one, becomes the head, and `pkt_pending` stays 1 while one remains. A `rd_release` with nothing pending is ignored.
- R7: A packet closed with `rx_end_bad` is discarded. It does not change `pkt_pending`, and the packets that follow keep their order.
- R8: A packet with more than BANK_BYTES bytes is discarded even if it ends with `rx_end_good`.
- R9: `rx_refuse` is 1 exactly while both banks hold unread packets. A packet that arrives during that time is discarded, and `rx_refuse` stays 1 until a release or a flush.
- R10: A `flush` pulse empties both banks. One cycle later `pkt_pending`, `dma_req` and `rx_refuse` are 0 and `rd_size` is 0. The following packet is received and read back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of both banks and all pointers |
| rx_valid | input | 1 | One packet byte on `rx_byte` this cycle |
| rx_byte | input | DATA_W | Received byte |
| rx_end_good | input | 1 | Packet finished without error (never together with `rx_valid`) |
| rx_end_bad | input | 1 | Packet finished with error (never together with `rx_valid`) |
| rx_refuse | output | 1 | Both banks occupied; incoming packets are refused |
| rd_strobe | input | 1 | Advance the data port by one byte |
| rd_release | input | 1 | Reader has finished the head packet |
| rd_data | output | DATA_W | Current byte of the head packet |
| rd_size | output | $clog2(BANK_BYTES+1) | Byte count of the head packet, 0 when none is pending |
| pkt_pending | output | 1 | At least one completed packet is unread |
| dma_req | output | 1 | Head packet has unread bytes |

## Verification
Packet lengths are drawn at random from the range 0 to BANK_BYTES+2, with a random share of error endings, and they are mixed with drains that do or do not over-read. This shows whether acceptance depends only on the length, the ending and the bank occupancy. Back-to-back packets fill both banks without any reads in between, which separates bank alternation and ordering from a single-bank scheme. A third packet sent into two full banks checks that a refused packet does not overwrite stored data. Exact-capacity, one-over-capacity and zero-length packets pin down the length boundary. Strobes and releases issued while the buffer is empty, followed by a normal packet, show whether idle reads disturb the read pointer.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

   localparam int unsigned PP_BANKS = 2;

   typedef logic bank_sel_t;

   function automatic bank_sel_t flip_bank(bank_sel_t b);
      return ~b;
   endfunction

   function automatic logic [PP_BANKS-1:0] bank_onehot(bank_sel_t b);
      return (b == 1'b0) ? 2'b01 : 2'b10;
   endfunction

endpackage

// File: rtl/pp_rx_bank_store.sv
module pp_rx_bank_store #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned BANK_BYTES = 64,
   localparam int unsigned PTR_W     = $clog2(BANK_BYTES)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_bank,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   import pp_rx_pkg::*;

   logic [DATA_W-1:0] bank_q [PP_BANKS];

   for (genvar b = 0; b < PP_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] mem [BANK_BYTES];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(b))) begin
            mem[wr_addr] <= wr_data;
         end
      end

      assign bank_q[b] = mem[rd_addr];
   end

   assign rd_data = bank_q[rd_bank];

endmodule

// File: rtl/pp_rx_bank_flag.sv
module pp_rx_bank_flag #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             set_i,
   input  logic [CNT_W-1:0] size_i,
   input  logic             release_i,
   output logic             full_o,
   output logic [CNT_W-1:0] size_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_o <= 1'b0;
         size_o <= '0;
      end else if (flush) begin
         full_o <= 1'b0;
         size_o <= '0;
      end else if (set_i) begin
         full_o <= 1'b1;
         size_o <= size_i;
      end else if (release_i) begin
         full_o <= 1'b0;
      end
   end

endmodule

// File: rtl/pp_rx_fill_ctl.sv
module pp_rx_fill_ctl #(
   parameter int unsigned BANK_BYTES = 64,
   localparam int unsigned PTR_W     = $clog2(BANK_BYTES),
   localparam int unsigned CNT_W     = $clog2(BANK_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             rx_valid,
   input  logic             rx_end_good,
   input  logic             rx_end_bad,
   input  logic [1:0]       bank_full,
   output logic             wr_en,
   output logic             wr_bank,
   output logic [PTR_W-1:0] wr_addr,
   output logic [1:0]       set_full,
   output logic [CNT_W-1:0] set_size,
   output logic             refuse
);
   import pp_rx_pkg::*;

   localparam logic [CNT_W-1:0] CAP = CNT_W'(BANK_BYTES);

   bank_sel_t        bank_q;
   logic [CNT_W-1:0] cnt_q;
   logic             drop_q;
   logic             room;
   logic             commit;

   assign refuse   = bank_full[bank_q];
   assign room     = (cnt_q < CAP);
   assign wr_en    = rx_valid && !refuse && !drop_q && room;
   assign wr_bank  = bank_q;
   assign wr_addr  = cnt_q[PTR_W-1:0];
   assign commit   = rx_end_good && !refuse && !drop_q;
   assign set_full = commit ? bank_onehot(bank_q) : 2'b00;
   assign set_size = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= 1'b0;
         cnt_q  <= '0;
         drop_q <= 1'b0;
      end else if (flush) begin
         bank_q <= 1'b0;
         cnt_q  <= '0;
         drop_q <= 1'b0;
      end else if (rx_end_good || rx_end_bad) begin
         cnt_q  <= '0;
         drop_q <= 1'b0;
         if (commit) begin
            bank_q <= flip_bank(bank_q);
         end
      end else if (rx_valid) begin
         if (wr_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end else begin
            drop_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pp_rx_drain_ctl.sv
module pp_rx_drain_ctl #(
   parameter int unsigned BANK_BYTES = 64,
   localparam int unsigned PTR_W     = $clog2(BANK_BYTES),
   localparam int unsigned CNT_W     = $clog2(BANK_BYTES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  rd_strobe,
   input  logic                  rd_release,
   input  logic [1:0]            bank_full,
   input  logic [1:0][CNT_W-1:0] bank_size,
   output logic                  rd_bank,
   output logic [PTR_W-1:0]      rd_addr,
   output logic [1:0]            clr_full,
   output logic [CNT_W-1:0]      head_size,
   output logic                  head_full,
   output logic                  dma_req
);
   import pp_rx_pkg::*;

   bank_sel_t        bank_q;
   logic [CNT_W-1:0] ptr_q;
   logic             more;
   logic             give_back;

   assign head_full = bank_full[bank_q];
   assign head_size = head_full ? bank_size[bank_q] : '0;
   assign more      = head_full && (ptr_q < head_size);
   assign dma_req   = more;
   assign give_back = rd_release && head_full;
   assign clr_full  = give_back ? bank_onehot(bank_q) : 2'b00;
   assign rd_bank   = bank_q;
   assign rd_addr   = ptr_q[PTR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= 1'b0;
         ptr_q  <= '0;
      end else if (flush) begin
         bank_q <= 1'b0;
         ptr_q  <= '0;
      end else if (give_back) begin
         bank_q <= flip_bank(bank_q);
         ptr_q  <= '0;
      end else if (rd_strobe && more) begin
         ptr_q <= ptr_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/pp_rx_buffer.sv
module pp_rx_buffer #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned BANK_BYTES = 64,
   localparam int unsigned PTR_W     = $clog2(BANK_BYTES),
   localparam int unsigned CNT_W     = $clog2(BANK_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_end_good,
   input  logic              rx_end_bad,
   output logic              rx_refuse,
   input  logic              rd_strobe,
   input  logic              rd_release,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  rd_size,
   output logic              pkt_pending,
   output logic              dma_req
);
   import pp_rx_pkg::*;

   if (BANK_BYTES < 2 || (BANK_BYTES & (BANK_BYTES - 1)) != 0) begin : g_bad_depth
      $error("pp_rx_buffer: BANK_BYTES must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("pp_rx_buffer: DATA_W must be at least 1");
   end

   logic                  wr_en;
   logic                  wr_bank;
   logic [PTR_W-1:0]      wr_addr;
   logic [1:0]            set_full;
   logic [CNT_W-1:0]      set_size;
   logic                  rd_bank;
   logic [PTR_W-1:0]      rd_addr;
   logic [1:0]            clr_full;
   logic [1:0]            bank_full;
   logic [1:0][CNT_W-1:0] bank_size;
   logic                  head_full;

   pp_rx_fill_ctl #(.BANK_BYTES(BANK_BYTES)) fill_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .rx_valid    (rx_valid),
      .rx_end_good (rx_end_good),
      .rx_end_bad  (rx_end_bad),
      .bank_full   (bank_full),
      .wr_en       (wr_en),
      .wr_bank     (wr_bank),
      .wr_addr     (wr_addr),
      .set_full    (set_full),
      .set_size    (set_size),
      .refuse      (rx_refuse)
   );

   for (genvar b = 0; b < PP_BANKS; b++) begin : g_flag
      pp_rx_bank_flag #(.CNT_W(CNT_W)) flag_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (flush),
         .set_i     (set_full[b]),
         .size_i    (set_size),
         .release_i (clr_full[b]),
         .full_o    (bank_full[b]),
         .size_o    (bank_size[b])
      );
   end

   pp_rx_bank_store #(.DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES)) store_i (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_bank (wr_bank),
      .wr_addr (wr_addr),
      .wr_data (rx_byte),
      .rd_bank (rd_bank),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   pp_rx_drain_ctl #(.BANK_BYTES(BANK_BYTES)) drain_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .rd_strobe  (rd_strobe),
      .rd_release (rd_release),
      .bank_full  (bank_full),
      .bank_size  (bank_size),
      .rd_bank    (rd_bank),
      .rd_addr    (rd_addr),
      .clr_full   (clr_full),
      .head_size  (rd_size),
      .head_full  (head_full),
      .dma_req    (dma_req)
   );

   assign pkt_pending = |bank_full;

endmodule

// File: rtl/pp_rx_buffer_chk.sv
module pp_rx_buffer_chk #(
   parameter int unsigned SIZE_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              rx_valid,
   input logic              rx_end_good,
   input logic              rx_end_bad,
   input logic              rx_refuse,
   input logic              rd_strobe,
   input logic              rd_release,
   input logic [SIZE_W-1:0] rd_size,
   input logic              pkt_pending,
   input logic              dma_req
);

   // input protocol: an end strobe never shares a cycle with a byte
   end_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_end_good || rx_end_bad) |-> !rx_valid);

   // R2
   pending_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_pending) |-> $past(rx_end_good));

   // R2
   size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_pending && !rd_release && !flush) |=> $stable(rd_size));

   // R4
   dma_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> pkt_pending);

   // R4
   dma_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_req) |-> ($past(rd_strobe) || $past(rd_release) || $past(flush)));

   // R7
   bad_end_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_end_bad && !pkt_pending && !flush) |=> !pkt_pending);

   // R9
   refuse_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_refuse |-> pkt_pending);

   // R9
   refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_refuse && !rd_release && !flush) |=> rx_refuse);

   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!pkt_pending && !dma_req && !rx_refuse && rd_size == '0));

endmodule

bind pp_rx_buffer pp_rx_buffer_chk #(.SIZE_W(CNT_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .rx_valid    (rx_valid),
   .rx_end_good (rx_end_good),
   .rx_end_bad  (rx_end_bad),
   .rx_refuse   (rx_refuse),
   .rd_strobe   (rd_strobe),
   .rd_release  (rd_release),
   .rd_size     (rd_size),
   .pkt_pending (pkt_pending),
   .dma_req     (dma_req)
);

// File: tb/pp_rx_buffer_tb_top.sv
`timescale 1ns/1ps
module pp_rx_buffer_tb_top;

   localparam int DW  = 8;
   localparam int CAP = 64;
   localparam int SW  = $clog2(CAP + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          flush, rx_valid, rx_end_good, rx_end_bad;
   logic [DW-1:0] rx_byte;
   logic          rx_refuse, rd_strobe, rd_release;
   logic [DW-1:0] rd_data;
   logic [SW-1:0] rd_size;
   logic          pkt_pending, dma_req;

   int total = 0;
   int bad   = 0;

   // reference model of queued packets
   logic [7:0] m_dat [2][CAP];
   int         m_len [2];
   int         m_head = 0;
   int         m_cnt  = 0;

   always #2.5 clk = ~clk;

   pp_rx_buffer #(.DATA_W(DW), .BANK_BYTES(CAP)) dut_i (
      .clk, .rst_n, .flush, .rx_valid, .rx_byte, .rx_end_good, .rx_end_bad,
      .rx_refuse, .rd_strobe, .rd_release, .rd_data, .rd_size,
      .pkt_pending, .dma_req
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_size();
      return (m_cnt > 0) ? m_len[m_head] : 0;
   endfunction

   function automatic bit accepted(int len, bit err);
      return !err && len <= CAP && m_cnt < 2;
   endfunction

   task automatic check_idle_state(string req);
      check({req, " pending"}, int'(pkt_pending), int'(m_cnt > 0));
      check({req, " size"},    int'(rd_size),     exp_size());
      check({req, " refuse"},  int'(rx_refuse),   int'(m_cnt == 2));
   endtask

   task automatic send_pkt(int len, bit err);
      logic [7:0] tmp [CAP];
      int slot;
      check("R9 refuse before packet", int'(rx_refuse), int'(m_cnt == 2));
      for (int i = 0; i < len; i++) begin
         rx_valid = 1'b1;
         rx_byte  = 8'($urandom);
         if (i < CAP) tmp[i] = rx_byte;
         @(negedge clk);
      end
      rx_valid = 1'b0;
      if (err) rx_end_bad = 1'b1; else rx_end_good = 1'b1;
      @(negedge clk);
      rx_end_bad  = 1'b0;
      rx_end_good = 1'b0;
      if (accepted(len, err)) begin
         slot = (m_head + m_cnt) % 2;
         m_len[slot] = len;
         for (int i = 0; i < len; i++) m_dat[slot][i] = tmp[i];
         m_cnt++;
      end
      check_idle_state(err ? "R7 after bad end" : (len > CAP ? "R8 after overflow" : "R2 after good end"));
   endtask

   task automatic drain(int extra);
      int len = m_len[m_head];
      check("R2 size at head", int'(rd_size), len);
      for (int i = 0; i < len; i++) begin
         check("R4 dma while bytes left", int'(dma_req), 1);
         check("R3 byte order", int'(rd_data), int'(m_dat[m_head][i]));
         rd_strobe = 1'b1;
         @(negedge clk);
         rd_strobe = 1'b0;
      end
      check("R4 dma after last byte", int'(dma_req), 0);
      for (int i = 0; i < extra; i++) begin
         rd_strobe = 1'b1;
         @(negedge clk);
         rd_strobe = 1'b0;
      end
      if (extra > 0) begin
         check("R5 size after over-read", int'(rd_size), len);
         check("R5 dma after over-read", int'(dma_req), 0);
      end
      rd_release = 1'b1;
      @(negedge clk);
      rd_release = 1'b0;
      m_head = (m_head + 1) % 2;
      m_cnt--;
      check_idle_state("R6 after release");
   endtask

   task automatic do_flush();
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      m_cnt  = 0;
      m_head = 0;
      check("R10 pending", int'(pkt_pending), 0);
      check("R10 dma", int'(dma_req), 0);
      check("R10 refuse", int'(rx_refuse), 0);
      check("R10 size", int'(rd_size), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0c0d));
      rst_n = 1'b0; flush = 1'b0; rx_valid = 1'b0; rx_byte = '0;
      rx_end_good = 1'b0; rx_end_bad = 1'b0; rd_strobe = 1'b0; rd_release = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pending", int'(pkt_pending), 0);
      check("R1 dma", int'(dma_req), 0);
      check("R1 refuse", int'(rx_refuse), 0);
      check("R1 size", int'(rd_size), 0);

      // R5 / R6: strobes and release while empty are ignored
      rd_strobe = 1'b1;
      repeat (3) @(negedge clk);
      rd_strobe = 1'b0;
      rd_release = 1'b1;
      @(negedge clk);
      rd_release = 1'b0;
      check("R6 release when empty", int'(pkt_pending), 0);
      check("R5 dma when empty", int'(dma_req), 0);
      send_pkt(5, 1'b0);
      drain(0);                                   // R5: read from byte 0

      // R9: two packets fill both banks, third refused
      send_pkt(CAP, 1'b0);                        // R2 exact capacity
      send_pkt(7, 1'b0);
      send_pkt(9, 1'b0);                          // refused while both full
      drain(2);
      check("R9 refuse after release", int'(rx_refuse), 0);
      drain(0);

      // R7 / R8: bad end and overflow discarded, ordering kept
      send_pkt(12, 1'b1);
      send_pkt(CAP + 1, 1'b0);
      send_pkt(3, 1'b0);
      send_pkt(CAP + 2, 1'b0);
      send_pkt(0, 1'b0);                          // zero-length packet
      drain(0);
      check("R4 zero-length dma", int'(dma_req), 0);
      drain(1);

      // R10: flush with both banks full, then normal traffic
      send_pkt(4, 1'b0);
      send_pkt(6, 1'b0);
      do_flush();
      send_pkt(8, 1'b0);
      drain(0);

      // constrained random mix
      for (int it = 0; it < 300; it++) begin
         int pick = int'($urandom % 3);
         if (pick < 2 || m_cnt == 0) begin
            send_pkt(int'($urandom % (CAP + 3)), ($urandom % 8) == 0);
         end else begin
            drain(int'($urandom % 3));
         end
      end
      while (m_cnt > 0) drain(0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule